// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt vectors raised by on-chip sources and stores each one as a 128-bit, 16-byte entry in a circular buffer in system memory. Its memory write port goes straight to a simple memory model. The block keeps the write pointer, and the host moves the read pointer forward by register writes once it has consumed entries. Both pointers count bytes. The ring size is a power of two set by software, and the ring start address is 256-byte aligned.

The block holds its level interrupt while the ring is enabled, interrupts are enabled and unread entries remain. A write that fills the ring can raise a sticky overflow flag. The flag appears as the top bit of the write pointer value and stays set until software clears it explicitly. As an option, each write-pointer update is also copied to a writeback address, so the host can poll memory instead of reading the register.

Top module: `irq_vec_ring`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and neither `mem_we` nor `wb_we` is asserted.
- R2: A vector offered on `vec_valid` is accepted only while control bit 0 (ring on) and control bit 1 (interrupts on) are both set. An accepted vector produces exactly one `mem_we` pulse in the next cycle, with `mem_wdata` equal to the vector. A vector that is not accepted leaves the pointers and outputs unchanged.
- R3: The entry address is the base register (offset 1, holding byte-address bits [39:8]) shifted left by 8, plus the write pointer value from before the write.
- R4: Each accepted vector advances the write pointer by 16 modulo 2^(S+2) bytes. S is control field [9:5], clamped to the range 2 to MAX_LOG2_DW. The write pointer reads back in bits [15:0] of offset 3.
- R5: When control bit 2 is set and an accepted vector moves the write pointer onto the read pointer, bit 31 of offset 3 becomes 1 and stays 1. The vector is still written and the pointer still advances.
- R6: A control write with bit 3 set clears the overflow flag. If a new overflow happens in the same cycle, the flag stays set.
- R7: While control bit 4 is set, every write-pointer update (a vector or a host write to offset 3) issues one `wb_we` pulse in the next cycle. The pulse goes to address {offset 5 [7:0], offset 4 [31:2], 2'b00} and carries the value that offset 3 reads after the update.
- R8: `irq` is high exactly when control bits 0 and 1 are set and the read pointer differs from the write pointer.
- R9: Host writes to offset 2 (read pointer) or offset 3 (write pointer) store the value masked to the ring size, with bits [3:0] cleared. A vector that arrives in the same cycle as a write to offset 3 is dropped. Writing zero to both pointers leaves the ring empty.
- R10: Control bit 31 reads 1 in any cycle where `mem_we` or `wb_we` is asserted. A control write with bit 10 set ignores its other bits. It zeroes both pointers and the flag, and clears control bits 0 and 1. It keeps the size, overflow-enable and writeback-enable settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_valid | input | 1 | A vector is offered this cycle |
| vec_data | input | VEC_W | Vector contents, four dwords |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_we | output | 1 | Ring entry write strobe |
| mem_addr | output | ADDR_W | Byte address of the ring entry |
| mem_wdata | output | VEC_W | Ring entry data |
| wb_we | output | 1 | Write-pointer writeback strobe |
| wb_addr | output | ADDR_W | Writeback byte address |
| wb_wdata | output | 32 | Writeback data (overflow flag and write pointer) |
| irq | output | 1 | Level interrupt: unread entries are pending |

## Verification
The hardest state to reach from the ports is a write-pointer wrap at the largest ring size. Getting there takes thousands of back-to-back vectors while the read pointer stays still, and the overflow compare must fire on exactly the last of them. The stimulus programs an out-of-range size code so that the clamp to the maximum is also exercised. It then streams 4096 vectors without a gap and reads the pointer one vector before the wrap and again just after it. A second hard case is a host pointer write that arrives in the same cycle as a vector. The bench raises both on the same edge, and the model decides which one wins.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int ENTRY_BYTES = 16;
    localparam int REG_AW      = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL = 3'd0,
        RA_BASE = 3'd1,
        RA_RPTR = 3'd2,
        RA_WPTR = 3'd3,
        RA_WBLO = 3'd4,
        RA_WBHI = 3'd5
    } reg_sel_e;

    // control register bit positions
    localparam int CB_RING   = 0;
    localparam int CB_INTR   = 1;
    localparam int CB_OVFEN  = 2;
    localparam int CB_OVFCLR = 3;
    localparam int CB_WBEN   = 4;
    localparam int CB_SZ_LO  = 5;
    localparam int CB_SZ_W   = 5;
    localparam int CB_SRST   = 10;
    localparam int CB_BUSY   = 31;
    localparam int WP_OVF    = 31;
endpackage

// File: rtl/ivr_ptr_step.sv
module ivr_ptr_step #(
    parameter int MAX_LOG2_DW = 14,
    parameter int PTR_W       = MAX_LOG2_DW + 2
) (
    input  logic [ivr_pkg::CB_SZ_W-1:0] size_code,
    input  logic [PTR_W-1:0]            wp,
    input  logic [PTR_W-1:0]            rp,
    output logic [PTR_W-1:0]            mask,
    output logic [PTR_W-1:0]            next_wp,
    output logic                        hits_rp
);
    localparam int SZ_W = ivr_pkg::CB_SZ_W;
    logic [SZ_W-1:0] szc;

    always_comb begin
        if (size_code < SZ_W'(2))
            szc = SZ_W'(2);
        else if (size_code > SZ_W'(MAX_LOG2_DW))
            szc = SZ_W'(MAX_LOG2_DW);
        else
            szc = size_code;
        mask    = PTR_W'((40'd1 << (szc + SZ_W'(2))) - 40'd1);
        next_wp = (wp + PTR_W'(ivr_pkg::ENTRY_BYTES)) & mask;
        hits_rp = (next_wp == rp);
    end
endmodule

// File: rtl/ivr_addr_gen.sv
module ivr_addr_gen #(
    parameter int ADDR_W = 40,
    parameter int BASE_W = 32,
    parameter int PTR_W  = 16
) (
    input  logic [BASE_W-1:0]    base,
    input  logic [PTR_W-1:0]     wp,
    input  logic [31:0]          wb_lo,
    input  logic [ADDR_W-33:0]   wb_hi,
    output logic [ADDR_W-1:0]    ring_addr,
    output logic [ADDR_W-1:0]    wb_addr
);
    localparam int ALIGN_W = ADDR_W - BASE_W;

    always_comb begin
        ring_addr = {base, {ALIGN_W{1'b0}}} + ADDR_W'(wp);
        wb_addr   = {wb_hi, wb_lo[31:2], 2'b00};
    end
endmodule

// File: rtl/irq_vec_ring.sv
module irq_vec_ring #(
    parameter int MAX_LOG2_DW = 14,
    parameter int ADDR_W      = 40,
    parameter int VEC_W       = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         vec_valid,
    input  logic [VEC_W-1:0]             vec_data,
    input  logic                         reg_we,
    input  logic [ivr_pkg::REG_AW-1:0]   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [VEC_W-1:0]             mem_wdata,
    output logic                         wb_we,
    output logic [ADDR_W-1:0]            wb_addr,
    output logic [31:0]                  wb_wdata,
    output logic                         irq
);
    import ivr_pkg::*;

    localparam int PTR_W   = MAX_LOG2_DW + 2;
    localparam int BASE_W  = 32;
    localparam int WB_HI_W = ADDR_W - 32;
    localparam logic [PTR_W-1:0] ALIGN_MASK = ~PTR_W'(ENTRY_BYTES - 1);

    typedef struct packed {
        logic                ring_en;
        logic                intr_en;
        logic                ovf_en;
        logic                wb_en;
        logic [CB_SZ_W-1:0]  size_code;
        logic [BASE_W-1:0]   base;
        logic [PTR_W-1:0]    rp;
        logic [PTR_W-1:0]    wp;
        logic                ovf;
        logic [31:0]         wb_lo;
        logic [WB_HI_W-1:0]  wb_hi;
        logic                mem_we;
        logic [ADDR_W-1:0]   mem_addr;
        logic [VEC_W-1:0]    mem_data;
        logic                wb_we;
        logic [ADDR_W-1:0]   wb_addr;
        logic [31:0]         wb_data;
    } ring_st_t;

    ring_st_t q, d;

    logic [PTR_W-1:0]  ptr_mask, next_wp;
    logic              hits_rp;
    logic [ADDR_W-1:0] ring_addr_c, wb_addr_c;

    ivr_ptr_step #(.MAX_LOG2_DW(MAX_LOG2_DW), .PTR_W(PTR_W)) step_i (
        .size_code (q.size_code),
        .wp        (q.wp),
        .rp        (q.rp),
        .mask      (ptr_mask),
        .next_wp   (next_wp),
        .hits_rp   (hits_rp)
    );

    ivr_addr_gen #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .PTR_W(PTR_W)) addr_i (
        .base      (q.base),
        .wp        (q.wp),
        .wb_lo     (q.wb_lo),
        .wb_hi     (q.wb_hi),
        .ring_addr (ring_addr_c),
        .wb_addr   (wb_addr_c)
    );

    logic wr_ctrl, wr_rp, wr_wp, srst, accept, ovf_hit, ovf_clr;

    always_comb begin
        wr_ctrl = reg_we && (reg_addr == RA_CTRL);
        wr_rp   = reg_we && (reg_addr == RA_RPTR);
        wr_wp   = reg_we && (reg_addr == RA_WPTR);
        srst    = wr_ctrl && reg_wdata[CB_SRST];
        ovf_clr = wr_ctrl && reg_wdata[CB_OVFCLR];
        accept  = vec_valid && q.ring_en && q.intr_en && !wr_wp && !srst;
        ovf_hit = accept && q.ovf_en && hits_rp;

        d        = q;
        d.mem_we = 1'b0;
        d.wb_we  = 1'b0;

        if (accept) begin
            d.wp       = next_wp;
            d.mem_we   = 1'b1;
            d.mem_addr = ring_addr_c;
            d.mem_data = vec_data;
        end
        if (wr_rp) d.rp = reg_wdata[PTR_W-1:0] & ptr_mask & ALIGN_MASK;
        if (wr_wp) d.wp = reg_wdata[PTR_W-1:0] & ptr_mask & ALIGN_MASK;
        if (reg_we && (reg_addr == RA_BASE)) d.base  = reg_wdata;
        if (reg_we && (reg_addr == RA_WBLO)) d.wb_lo = {reg_wdata[31:2], 2'b00};
        if (reg_we && (reg_addr == RA_WBHI)) d.wb_hi = reg_wdata[WB_HI_W-1:0];
        if (wr_ctrl && !srst) begin
            d.ring_en   = reg_wdata[CB_RING];
            d.intr_en   = reg_wdata[CB_INTR];
            d.ovf_en    = reg_wdata[CB_OVFEN];
            d.wb_en     = reg_wdata[CB_WBEN];
            d.size_code = reg_wdata[CB_SZ_LO +: CB_SZ_W];
        end

        d.ovf = (q.ovf && !ovf_clr) || ovf_hit;

        if (q.wb_en && (accept || wr_wp)) begin
            d.wb_we   = 1'b1;
            d.wb_addr = wb_addr_c;
            d.wb_data = {d.ovf, {(31-PTR_W){1'b0}}, d.wp};
        end

        if (srst) begin
            d.rp      = '0;
            d.wp      = '0;
            d.ovf     = 1'b0;
            d.ring_en = 1'b0;
            d.intr_en = 1'b0;
            d.mem_we  = 1'b0;
            d.wb_we   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_RING]               = q.ring_en;
                reg_rdata[CB_INTR]               = q.intr_en;
                reg_rdata[CB_OVFEN]              = q.ovf_en;
                reg_rdata[CB_WBEN]               = q.wb_en;
                reg_rdata[CB_SZ_LO +: CB_SZ_W]   = q.size_code;
                reg_rdata[CB_BUSY]               = q.mem_we | q.wb_we;
            end
            RA_BASE: reg_rdata = q.base;
            RA_RPTR: reg_rdata[PTR_W-1:0] = q.rp;
            RA_WPTR: begin
                reg_rdata[PTR_W-1:0] = q.wp;
                reg_rdata[WP_OVF]    = q.ovf;
            end
            RA_WBLO: reg_rdata = q.wb_lo;
            RA_WBHI: reg_rdata[WB_HI_W-1:0] = q.wb_hi;
            default: reg_rdata = '0;
        endcase
    end

    assign mem_we    = q.mem_we;
    assign mem_addr  = q.mem_addr;
    assign mem_wdata = q.mem_data;
    assign wb_we     = q.wb_we;
    assign wb_addr   = q.wb_addr;
    assign wb_wdata  = q.wb_data;
    assign irq       = q.ring_en && q.intr_en && (q.rp != q.wp);

    // R2: an entry write only follows an offered vector
    a_r2_write_needs_vector: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(vec_valid));

    // R3: entry addresses are 16-byte aligned
    a_r3_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[3:0] == 4'h0));

    // R6: the sticky flag falls only after an explicit clear or soft reset
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ovf) |-> $past(reg_we && (reg_addr == RA_CTRL) &&
                               (reg_wdata[CB_OVFCLR] || reg_wdata[CB_SRST])));

    // R7: the writeback value matches the live pointer state
    a_r7_wb_matches_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> (wb_wdata[PTR_W-1:0] == q.wp) && (wb_wdata[31] == q.ovf));

    // R10: a soft reset leaves the ring empty and quiet
    a_r10_soft_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_SRST]) |->
            (q.wp == '0) && (q.rp == '0) && !irq && !mem_we && !wb_we);
endmodule

// File: tb/irq_vec_ring_tb_top.sv
module irq_vec_ring_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXL       = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vec_valid = 1'b0;
    logic [127:0] vec_data = '0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         mem_we, wb_we, irq;
    logic [39:0]  mem_addr, wb_addr;
    logic [127:0] mem_wdata;
    logic [31:0]  wb_wdata;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vec_ring dut_i (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_data(vec_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wb_we(wb_we), .wb_addr(wb_addr),
        .wb_wdata(wb_wdata), .irq(irq)
    );

    // behavioural reference model
    bit        m_ring, m_intr, m_ovfen, m_wben, m_ovf;
    bit [4:0]  m_sz;
    bit [31:0] m_base, m_wblo;
    bit [7:0]  m_wbhi;
    int        m_rp, m_wp;
    bit        e_mem_we, e_wb_we;
    bit [39:0] e_mem_addr, e_wb_addr;
    bit [127:0] e_mem_data;
    bit [31:0] e_wb_data;
    int        szc, msk, nwp;
    bit        acc, nov;

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_ring, m_intr, m_ovfen, m_wben, m_ovf} = '0;
            m_sz = 0; m_base = 0; m_wblo = 0; m_wbhi = 0; m_rp = 0; m_wp = 0;
            e_mem_we = 0; e_wb_we = 0; e_mem_addr = 0; e_wb_addr = 0;
            e_mem_data = 0; e_wb_data = 0;
        end else begin
            szc = (m_sz < 2) ? 2 : ((m_sz > MAXL) ? MAXL : int'(m_sz));
            msk = (1 << (szc + 2)) - 1;
            e_mem_we = 0;
            e_wb_we  = 0;
            if (reg_we && reg_addr == 0 && reg_wdata[10]) begin
                m_rp = 0; m_wp = 0; m_ovf = 0; m_ring = 0; m_intr = 0;
            end else begin
                acc = vec_valid && m_ring && m_intr && !(reg_we && reg_addr == 3);
                nov = m_ovf && !(reg_we && reg_addr == 0 && reg_wdata[3]);
                nwp = m_wp;
                if (acc) begin
                    e_mem_we   = 1;
                    e_mem_addr = {m_base, 8'h00} + 40'(m_wp);
                    e_mem_data = vec_data;
                    nwp = (m_wp + 16) & msk;
                    if (m_ovfen && nwp == m_rp) nov = 1;
                end
                if (reg_we && reg_addr == 3) nwp = int'(reg_wdata[15:0]) & msk & 'hFFF0;
                if (reg_we && reg_addr == 2) m_rp = int'(reg_wdata[15:0]) & msk & 'hFFF0;
                if (m_wben && (acc || (reg_we && reg_addr == 3))) begin
                    e_wb_we   = 1;
                    e_wb_addr = {m_wbhi, m_wblo[31:2], 2'b00};
                    e_wb_data = {nov, 15'b0, 16'(nwp)};
                end
                m_wp  = nwp;
                m_ovf = nov;
                if (reg_we) begin
                    case (reg_addr)
                        3'd0: begin
                            m_ring = reg_wdata[0]; m_intr = reg_wdata[1];
                            m_ovfen = reg_wdata[2]; m_wben = reg_wdata[4];
                            m_sz = reg_wdata[9:5];
                        end
                        3'd1: m_base = reg_wdata;
                        3'd4: m_wblo = {reg_wdata[31:2], 2'b00};
                        3'd5: m_wbhi = reg_wdata[7:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic void chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    function automatic logic [31:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return {e_mem_we | e_wb_we, 20'b0, 1'b0, m_sz, m_wben, 1'b0, m_ovfen, m_intr, m_ring};
            3'd1: return m_base;
            3'd2: return {16'b0, 16'(m_rp)};
            3'd3: return {m_ovf, 15'b0, 16'(m_wp)};
            3'd4: return m_wblo;
            3'd5: return {24'b0, m_wbhi};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(logic [2:0] a);
        case (a)
            3'd0: return "R10";
            3'd1: return "R3";
            3'd2: return "R9";
            3'd3: return "R4";
            default: return "R7";
        endcase
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", 128'(mem_we), 128'(e_mem_we));
            if (e_mem_we) begin
                chk("R3", 128'(mem_addr), 128'(e_mem_addr));
                chk("R2", mem_wdata, e_mem_data);
            end
            chk("R7", 128'(wb_we), 128'(e_wb_we));
            if (e_wb_we) begin
                chk("R7", 128'(wb_addr), 128'(e_wb_addr));
                chk("R7", 128'(wb_wdata), 128'(e_wb_data));
            end
            chk("R8", 128'(irq), 128'(m_ring && m_intr && (m_rp != m_wp)));
            chk(rd_tag(reg_addr), 128'(reg_rdata), 128'(exp_rd(reg_addr)));
        end
    end

    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        step();
        reg_we = 1'b0;
    endtask

    task automatic push(input int tagv);
        vec_valid = 1'b1;
        vec_data  = {32'(tagv) ^ 32'hA5A5_0000, 32'hC0DE_0000 | 32'(tagv), ~32'(tagv), 32'(tagv * 7)};
        step();
        vec_valid = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        chk(tag, 128'(reg_rdata), 128'(exp));
        step();
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk);
        chk(tag, 128'(irq), 128'(exp));
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 6; a++) rd_chk(3'(a), 32'h0, "R1");
        irq_chk(1'b0, "R1");

        // configure: base, writeback address, 4-entry ring with overflow and writeback
        wr(3'd1, 32'h0001_2345);
        wr(3'd4, 32'hABCD_0007);
        wr(3'd5, 32'h0000_0155);
        rd_chk(3'd5, 32'h55, "R7");
        wr(3'd0, 32'h97);
        for (int i = 0; i < 3; i++) push(i);
        rd_chk(3'd3, 32'h30, "R4");
        irq_chk(1'b1, "R8");

        // R5: fill onto the read pointer
        push(3);
        rd_chk(3'd3, 32'h8000_0000, "R5");
        irq_chk(1'b0, "R8");
        push(4);
        rd_chk(3'd3, 32'h8000_0010, "R5");

        // R6: explicit clear
        wr(3'd0, 32'h9F);
        rd_chk(3'd3, 32'h10, "R6");

        // R9: host read pointer writes, masked and aligned
        wr(3'd2, 32'h10);
        irq_chk(1'b0, "R8");
        wr(3'd2, 32'h23);
        rd_chk(3'd2, 32'h20, "R9");
        irq_chk(1'b1, "R8");

        // R2: interrupts off blocks acceptance
        wr(3'd0, 32'h95);
        push(5);
        rd_chk(3'd3, 32'h10, "R2");
        irq_chk(1'b0, "R8");

        // R9: vector and write-pointer write collide
        wr(3'd0, 32'h97);
        vec_valid = 1'b1; vec_data = {4{32'hDEAD_BEEF}};
        wr(3'd3, 32'h30);
        vec_valid = 1'b0;
        rd_chk(3'd3, 32'h30, "R9");

        // R9: disable ring then zero both pointers
        wr(3'd0, 32'h96);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0);
        rd_chk(3'd3, 32'h0, "R9");
        rd_chk(3'd2, 32'h0, "R9");

        // R4: size code above the maximum clamps to a 64 KiB ring
        wr(3'd0, 32'h3F7);
        for (int i = 0; i < 4095; i++) push(100 + i);
        rd_chk(3'd3, 32'h0000_FFF0, "R4");
        push(9999);
        rd_chk(3'd3, 32'h8000_0000, "R4");
        wr(3'd0, 32'h3FF);

        // R5: size code below the minimum clamps to a single entry
        wr(3'd0, 32'h17);
        push(42);
        rd_chk(3'd3, 32'h8000_0000, "R5");
        wr(3'd0, 32'h9F);
        rd_chk(3'd3, 32'h0, "R6");

        // R7: writeback off, then R10: busy while writing
        wr(3'd0, 32'h87);
        push(50);
        rd_chk(3'd0, 32'h8000_0087, "R10");
        rd_chk(3'd0, 32'h87, "R10");
        rd_chk(3'd3, 32'h10, "R4");

        // R10: soft reset
        push(51);
        wr(3'd0, 32'h497);
        rd_chk(3'd0, 32'h84, "R10");
        rd_chk(3'd3, 32'h0, "R10");
        rd_chk(3'd2, 32'h0, "R10");
        irq_chk(1'b0, "R10");
        push(52);
        rd_chk(3'd3, 32'h0, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule